// File: doc/BRIEF.md
# ECC Error Reporting Status Unit

This unit sits beside a RAM controller and a flash controller and turns their ECC event pulses into a small, software-visible record of the latest fault. Each controller reports two kinds of event: a corrected single-bit error and an uncorrectable multi-bit error. Each event arrives as a single-cycle pulse together with the faulting address, the access attributes and the data word. There are four event categories, and each has its own enable bit. An event in an enabled category is accepted. It then becomes the only flag set in a one-hot status register, and its address, attributes and data are latched into three capture registers.

Interrupt requests come straight from the enable and status registers. There is a single-bit request, separate RAM and flash uncorrectable requests, a combined uncorrectable request, and an overall request. A newer accepted event always replaces a pending one, so the capture registers always describe the flag that is currently set. Software reads the registers over a plain address/data port. It clears the reported flag by writing a 1 to that flag's position.

Top module: `ecc_event_monitor`

## Requirements
- R1: After reset, the enable register, the status register and all capture registers read zero, and every interrupt output is low.
- R2: The enable register sits at address 0. Bit 7 enables flash uncorrectable events, bit 6 RAM uncorrectable, bit 5 flash corrected and bit 4 RAM corrected. Bits 3..0 ignore writes and read zero.
- R3: The status register sits at address 1. Bit 1 flags RAM uncorrectable, bit 0 flash uncorrectable, bit 5 RAM corrected and bit 4 flash corrected. All other bits read zero, and at most one bit is ever set.
- R4: An accepted event sets its category flag and clears any other flag, visible in the cycle after the pulse.
- R5: On the same clock edge, an accepted event loads its own address, attributes and data into the capture registers. These read at addresses 2, 3 and 4 respectively, zero-extended.
- R6: An event whose category enable is 0 changes neither the status register nor the capture registers.
- R7: irqSingle equals (enable bit 4 AND status bit 5) OR (enable bit 5 AND status bit 4).
- R8: irqRamMulti equals enable bit 6 AND status bit 1. irqFlashMulti equals enable bit 7 AND status bit 0. irqMulti is their OR, and irqAny is irqSingle OR irqMulti. Clearing an enable therefore drops the request while the flag stays set.
- R9: Writing address 1 clears each status bit written as 1. Bits written as 0, and 1s written to bits that are not set, have no effect.
- R10: When several enabled events arrive in one cycle, the order of precedence is RAM uncorrectable, then flash uncorrectable, then RAM corrected, then flash corrected. The winner alone sets its flag and loads the capture registers.
- R11: When a status clear write and an accepted event occur in the same cycle, the event's flag is set after that edge.
- R12: Reads at addresses 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ramCorrPulse | input | 1 | RAM corrected single-bit event pulse |
| ramUncorrPulse | input | 1 | RAM uncorrectable event pulse |
| ramFaultAddr | input | ADDR_W | RAM faulting address |
| ramFaultAttr | input | ATTR_W | RAM access attributes |
| ramFaultData | input | DATA_W | RAM data word |
| flashCorrPulse | input | 1 | Flash corrected single-bit event pulse |
| flashUncorrPulse | input | 1 | Flash uncorrectable event pulse |
| flashFaultAddr | input | ADDR_W | Flash faulting address |
| flashFaultAttr | input | ATTR_W | Flash access attributes |
| flashFaultData | input | DATA_W | Flash data word |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | REG_DW | Register read data (combinational) |
| irqSingle | output | 1 | Corrected-error interrupt request |
| irqRamMulti | output | 1 | RAM uncorrectable interrupt request |
| irqFlashMulti | output | 1 | Flash uncorrectable interrupt request |
| irqMulti | output | 1 | Any uncorrectable interrupt request |
| irqAny | output | 1 | Overall ECC interrupt request |

## Verification
The interrupt outputs are formed without registers from the enable and status state. A wrong flag or a stale enable therefore shows on the request lines in the very cycle after the event or write that caused it. A status value that is not one-hot, or that has the wrong bit set, is caught by reading address 1 straight after the pulse. A capture register loaded from the wrong controller, or loaded by a rejected event, shows as a mismatch at addresses 2 to 4 on the next read. The same-cycle cases, where several events arrive together or an event meets a clear, are driven on purpose so that an arbitration fault appears as the wrong flag one cycle later.

// File: rtl/eccmon_pkg.sv
package eccmon_pkg;
  // enable register bit positions
  localparam int EN_RAM1    = 4;
  localparam int EN_FLASH1  = 5;
  localparam int EN_RAMNC   = 6;
  localparam int EN_FLASHNC = 7;
  localparam logic [7:0] EN_MASK = 8'hF0;

  // status register bit positions
  localparam int ST_FLASHNC = 0;
  localparam int ST_RAMNC   = 1;
  localparam int ST_FLASH1  = 4;
  localparam int ST_RAM1    = 5;

  // register map
  localparam logic [2:0] RA_ENABLE = 3'd0;
  localparam logic [2:0] RA_STATUS = 3'd1;
  localparam logic [2:0] RA_FADDR  = 3'd2;
  localparam logic [2:0] RA_FATTR  = 3'd3;
  localparam logic [2:0] RA_FDATA  = 3'd4;

  // control to datapath strobes
  typedef struct packed {
    logic capture;
    logic fromFlash;
  } capStrobe_t;
endpackage

// File: rtl/eccmon_ctrl.sv
module eccmon_ctrl
  import eccmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ramCorr,
  input  logic       ramUncorr,
  input  logic       flashCorr,
  input  logic       flashUncorr,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] enableQ,
  output logic [7:0] statusQ,
  output capStrobe_t strobe,
  output logic       irqSingle,
  output logic       irqRamMulti,
  output logic       irqFlashMulti,
  output logic       irqMulti,
  output logic       irqAny
);
  logic ramNcHit, flashNcHit, ram1Hit, flash1Hit;
  logic [7:0] newFlag, statusD, enableD;
  logic wrEnable, wrStatus;

  assign ramNcHit   = ramUncorr   & enableQ[EN_RAMNC];
  assign flashNcHit = flashUncorr & enableQ[EN_FLASHNC];
  assign ram1Hit    = ramCorr     & enableQ[EN_RAM1];
  assign flash1Hit  = flashCorr   & enableQ[EN_FLASH1];

  assign wrEnable = regWrEn && (regAddr == RA_ENABLE);
  assign wrStatus = regWrEn && (regAddr == RA_STATUS);

  // fixed-priority pick among accepted events
  always_comb begin
    newFlag          = '0;
    strobe.capture   = 1'b1;
    strobe.fromFlash = 1'b0;
    if (ramNcHit) begin
      newFlag[ST_RAMNC] = 1'b1;
    end else if (flashNcHit) begin
      newFlag[ST_FLASHNC] = 1'b1;
      strobe.fromFlash    = 1'b1;
    end else if (ram1Hit) begin
      newFlag[ST_RAM1] = 1'b1;
    end else if (flash1Hit) begin
      newFlag[ST_FLASH1] = 1'b1;
      strobe.fromFlash   = 1'b1;
    end else begin
      strobe.capture = 1'b0;
    end
  end

  always_comb begin
    if (strobe.capture)  statusD = newFlag;
    else if (wrStatus)   statusD = statusQ & ~regWrData;
    else                 statusD = statusQ;
    enableD = wrEnable ? (regWrData & EN_MASK) : enableQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= statusD;
      enableQ <= enableD;
    end
  end

  assign irqSingle     = (enableQ[EN_RAM1] & statusQ[ST_RAM1]) |
                         (enableQ[EN_FLASH1] & statusQ[ST_FLASH1]);
  assign irqRamMulti   = enableQ[EN_RAMNC] & statusQ[ST_RAMNC];
  assign irqFlashMulti = enableQ[EN_FLASHNC] & statusQ[ST_FLASHNC];
  assign irqMulti      = irqRamMulti | irqFlashMulti;
  assign irqAny        = irqSingle | irqMulti;
endmodule

// File: rtl/eccmon_dp.sv
module eccmon_dp
  import eccmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_DW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [ADDR_W-1:0] ramAddr,
  input  logic [ATTR_W-1:0] ramAttr,
  input  logic [DATA_W-1:0] ramData,
  input  logic [ADDR_W-1:0] flashAddr,
  input  logic [ATTR_W-1:0] flashAttr,
  input  logic [DATA_W-1:0] flashData,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        enableQ,
  input  logic [7:0]        statusQ,
  output logic [ADDR_W-1:0] faultAddrQ,
  output logic [REG_DW-1:0] regRdData
);
  logic [ATTR_W-1:0] faultAttrQ;
  logic [DATA_W-1:0] faultDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultAddrQ <= '0;
      faultAttrQ <= '0;
      faultDataQ <= '0;
    end else if (strobe.capture) begin
      faultAddrQ <= strobe.fromFlash ? flashAddr : ramAddr;
      faultAttrQ <= strobe.fromFlash ? flashAttr : ramAttr;
      faultDataQ <= strobe.fromFlash ? flashData : ramData;
    end
  end

  always_comb begin
    unique case (regAddr)
      RA_ENABLE: regRdData = REG_DW'(enableQ);
      RA_STATUS: regRdData = REG_DW'(statusQ);
      RA_FADDR:  regRdData = REG_DW'(faultAddrQ);
      RA_FATTR:  regRdData = REG_DW'(faultAttrQ);
      RA_FDATA:  regRdData = REG_DW'(faultDataQ);
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/ecc_event_monitor.sv
module ecc_event_monitor
  import eccmon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ATTR_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_DW = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ramCorrPulse,
  input  logic              ramUncorrPulse,
  input  logic [ADDR_W-1:0] ramFaultAddr,
  input  logic [ATTR_W-1:0] ramFaultAttr,
  input  logic [DATA_W-1:0] ramFaultData,
  input  logic              flashCorrPulse,
  input  logic              flashUncorrPulse,
  input  logic [ADDR_W-1:0] flashFaultAddr,
  input  logic [ATTR_W-1:0] flashFaultAttr,
  input  logic [DATA_W-1:0] flashFaultData,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [REG_DW-1:0] regRdData,
  output logic              irqSingle,
  output logic              irqRamMulti,
  output logic              irqFlashMulti,
  output logic              irqMulti,
  output logic              irqAny
);
  capStrobe_t        strobe;
  logic [7:0]        enableQ;
  logic [7:0]        statusQ;
  logic [ADDR_W-1:0] faultAddrQ;

  eccmon_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .ramCorr(ramCorrPulse), .ramUncorr(ramUncorrPulse),
    .flashCorr(flashCorrPulse), .flashUncorr(flashUncorrPulse),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .enableQ(enableQ), .statusQ(statusQ), .strobe(strobe),
    .irqSingle(irqSingle), .irqRamMulti(irqRamMulti),
    .irqFlashMulti(irqFlashMulti), .irqMulti(irqMulti), .irqAny(irqAny)
  );

  eccmon_dp #(
    .ADDR_W(ADDR_W), .ATTR_W(ATTR_W), .DATA_W(DATA_W), .REG_DW(REG_DW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ramAddr(ramFaultAddr), .ramAttr(ramFaultAttr), .ramData(ramFaultData),
    .flashAddr(flashFaultAddr), .flashAttr(flashFaultAttr), .flashData(flashFaultData),
    .regAddr(regAddr), .enableQ(enableQ), .statusQ(statusQ),
    .faultAddrQ(faultAddrQ), .regRdData(regRdData)
  );
endmodule

// File: rtl/eccmon_checker.sv
module eccmon_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              ramCorrPulse,
  input logic              ramUncorrPulse,
  input logic              flashCorrPulse,
  input logic              flashUncorrPulse,
  input logic [ADDR_W-1:0] ramFaultAddr,
  input logic [ADDR_W-1:0] flashFaultAddr,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic [7:0]        regWrData,
  input logic [7:0]        enableQ,
  input logic [7:0]        statusQ,
  input logic [ADDR_W-1:0] faultAddrQ,
  input logic              irqSingle,
  input logic              irqRamMulti,
  input logic              irqMulti,
  input logic              irqAny
);
  logic anyHit, enWrite, stWrite;
  assign anyHit = (ramUncorrPulse & enableQ[6]) | (flashUncorrPulse & enableQ[7]) |
                  (ramCorrPulse & enableQ[4]) | (flashCorrPulse & enableQ[5]);
  assign enWrite = regWrEn && (regAddr == 3'd0);
  assign stWrite = regWrEn && (regAddr == 3'd1);

  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(statusQ));

  assert_ramnc_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ramUncorrPulse && enableQ[6]) |=> (statusQ == 8'h02));

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ramUncorrPulse && enableQ[6]) |=> (faultAddrQ == $past(ramFaultAddr)));

  assert_ignore_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!anyHit && !stWrite) |=> ($stable(statusQ) && $stable(faultAddrQ)));

  assert_single_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ramCorrPulse && enableQ[4] && !ramUncorrPulse && !flashUncorrPulse && !enWrite)
      |=> (irqSingle && !irqMulti && irqAny));

  assert_multi_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ramUncorrPulse && enableQ[6] && !enWrite) |=> (irqRamMulti && irqMulti && irqAny));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stWrite && ((regWrData & statusQ) != 8'h00) && !anyHit) |=> (statusQ == 8'h00));

  assert_priority_R10: assert property (@(posedge clk) disable iff (!rstN)
    (flashUncorrPulse && enableQ[7] && ramCorrPulse && !(ramUncorrPulse && enableQ[6]))
      |=> (statusQ == 8'h01 && faultAddrQ == $past(flashFaultAddr)));

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stWrite && anyHit) |=> (statusQ != 8'h00));
endmodule

bind ecc_event_monitor eccmon_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .ramCorrPulse(ramCorrPulse), .ramUncorrPulse(ramUncorrPulse),
  .flashCorrPulse(flashCorrPulse), .flashUncorrPulse(flashUncorrPulse),
  .ramFaultAddr(ramFaultAddr), .flashFaultAddr(flashFaultAddr),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .enableQ(enableQ), .statusQ(statusQ), .faultAddrQ(faultAddrQ),
  .irqSingle(irqSingle), .irqRamMulti(irqRamMulti),
  .irqMulti(irqMulti), .irqAny(irqAny)
);

// File: tb/ecc_event_monitor_tb.sv
module ecc_event_monitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ramCorrPulse = 0, ramUncorrPulse = 0, flashCorrPulse = 0, flashUncorrPulse = 0;
  logic [31:0] ramFaultAddr = '0, ramFaultData = '0, flashFaultAddr = '0, flashFaultData = '0;
  logic [7:0]  ramFaultAttr = '0, flashFaultAttr = '0;
  logic        regWrEn = 0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [31:0] regRdData;
  logic        irqSingle, irqRamMulti, irqFlashMulti, irqMulti, irqAny;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_event_monitor dut_i (
    .clk(clk), .rstN(rstN),
    .ramCorrPulse(ramCorrPulse), .ramUncorrPulse(ramUncorrPulse),
    .ramFaultAddr(ramFaultAddr), .ramFaultAttr(ramFaultAttr), .ramFaultData(ramFaultData),
    .flashCorrPulse(flashCorrPulse), .flashUncorrPulse(flashUncorrPulse),
    .flashFaultAddr(flashFaultAddr), .flashFaultAttr(flashFaultAttr),
    .flashFaultData(flashFaultData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqSingle(irqSingle), .irqRamMulti(irqRamMulti), .irqFlashMulti(irqFlashMulti),
    .irqMulti(irqMulti), .irqAny(irqAny)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 0;
  endtask

  task automatic setFields(input logic [31:0] ra, input logic [31:0] fa);
    ramFaultAddr = ra;   ramFaultAttr = ra[7:0] ^ 8'h5A;   ramFaultData = ~ra;
    flashFaultAddr = fa; flashFaultAttr = fa[7:0] ^ 8'hA5; flashFaultData = ~fa;
  endtask

  task automatic pulse(input logic rc, input logic ru, input logic fc, input logic fu);
    ramCorrPulse = rc; ramUncorrPulse = ru; flashCorrPulse = fc; flashUncorrPulse = fu;
    tick();
    ramCorrPulse = 0; ramUncorrPulse = 0; flashCorrPulse = 0; flashUncorrPulse = 0;
  endtask

  task automatic checkCapture(input string req, input logic [31:0] a, input logic [7:0] at);
    logic [31:0] d;
    readReg(3'd2, d); check(req, d, a);
    readReg(3'd3, d); check(req, d, {24'h0, at});
    readReg(3'd4, d); check(req, d, ~a);
  endtask

  task automatic checkIrq(input string req, input logic [4:0] exp);
    check(req, {27'h0, irqSingle, irqRamMulti, irqFlashMulti, irqMulti, irqAny}, {27'h0, exp});
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      readReg(3'(a), d);
      check("R1 reset register", d, 32'h0);
    end
    checkIrq("R1 reset irq", 5'b00000);
  endtask

  task automatic testEnableMap();
    logic [31:0] d;
    writeReg(3'd0, 8'hFF);
    readReg(3'd0, d); check("R2 enable writable bits", d, 32'hF0);
    writeReg(3'd0, 8'h0F);
    readReg(3'd0, d); check("R2 low bits read zero", d, 32'h00);
    writeReg(3'd0, 8'h10);
  endtask

  task automatic testRamSingle();
    logic [31:0] d;
    setFields(32'h1000_0040, 32'h2000_0080);
    pulse(1, 0, 0, 0);
    readReg(3'd1, d); check("R4 ram corrected flag", d, 32'h20);
    checkCapture("R5 ram capture", 32'h1000_0040, 8'h40 ^ 8'h5A);
    checkIrq("R7 single irq", 5'b10001);
  endtask

  task automatic testDisabled();
    logic [31:0] d;
    setFields(32'h1111_0004, 32'h2222_0008);
    pulse(0, 0, 1, 1);
    readReg(3'd1, d); check("R6 disabled events ignored status", d, 32'h20);
    checkCapture("R6 disabled events ignored capture", 32'h1000_0040, 8'h40 ^ 8'h5A);
    checkIrq("R6 irq unchanged", 5'b10001);
  endtask

  task automatic testReplace();
    logic [31:0] d;
    writeReg(3'd0, 8'h90);
    setFields(32'h1234_0010, 32'h3456_0020);
    pulse(0, 0, 0, 1);
    readReg(3'd1, d); check("R4 flash uncorrectable replaces", d, 32'h01);
    checkCapture("R5 flash capture", 32'h3456_0020, 8'h20 ^ 8'hA5);
    checkIrq("R8 flash multi irq", 5'b00111);
  endtask

  task automatic testClear();
    logic [31:0] d;
    writeReg(3'd1, 8'h02);
    readReg(3'd1, d); check("R9 clear other bit no effect", d, 32'h01);
    checkIrq("R9 irq still pending", 5'b00111);
    writeReg(3'd1, 8'h01);
    readReg(3'd1, d); check("R9 w1c clears flag", d, 32'h00);
    checkIrq("R9 irq removed", 5'b00000);
  endtask

  task automatic testEnableGate();
    logic [31:0] d;
    writeReg(3'd0, 8'hF0);
    setFields(32'h0ABC_0100, 32'h0DEF_0200);
    pulse(0, 1, 0, 0);
    readReg(3'd1, d); check("R4 ram uncorrectable flag", d, 32'h02);
    checkIrq("R8 ram multi irq", 5'b01011);
    writeReg(3'd0, 8'hB0);
    readReg(3'd1, d); check("R8 flag kept after enable clear", d, 32'h02);
    checkIrq("R8 irq gated by enable", 5'b00000);
    writeReg(3'd1, 8'h02);
  endtask

  task automatic testPriority();
    logic [31:0] d;
    writeReg(3'd0, 8'hF0);
    setFields(32'h4000_0001, 32'h5000_0002);
    pulse(1, 1, 1, 1);
    readReg(3'd1, d); check("R10 ram uncorrectable first", d, 32'h02);
    checkCapture("R10 ram capture wins", 32'h4000_0001, 8'h01 ^ 8'h5A);
    setFields(32'h4000_0003, 32'h5000_0004);
    pulse(1, 0, 0, 1);
    readReg(3'd1, d); check("R10 flash uncorrectable over ram corrected", d, 32'h01);
    checkCapture("R10 flash capture wins", 32'h5000_0004, 8'h04 ^ 8'hA5);
    setFields(32'h4000_0005, 32'h5000_0006);
    pulse(1, 0, 1, 0);
    readReg(3'd1, d); check("R10 ram corrected over flash corrected", d, 32'h20);
    checkCapture("R10 ram corrected capture", 32'h4000_0005, 8'h05 ^ 8'h5A);
  endtask

  task automatic testEventVsClear();
    logic [31:0] d;
    setFields(32'h6000_0007, 32'h7000_0008);
    regWrEn = 1; regAddr = 3'd1; regWrData = 8'hFF;
    flashCorrPulse = 1;
    tick();
    regWrEn = 0; flashCorrPulse = 0;
    readReg(3'd1, d); check("R11 event wins over clear", d, 32'h10);
    checkIrq("R11 single irq held", 5'b10001);
    regWrEn = 1; regAddr = 3'd1; regWrData = 8'h10;
    ramCorrPulse = 1;
    tick();
    regWrEn = 0; ramCorrPulse = 0;
    readReg(3'd1, d); check("R11 new flag after same-cycle clear", d, 32'h20);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    for (int a = 5; a < 8; a++) begin
      readReg(3'(a), d);
      check("R12 unmapped reads zero", d, 32'h0);
    end
    readReg(3'd1, d); check("R3 status one-hot after sequence", d, 32'h20);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    testReset();
    testEnableMap();
    testRamSingle();
    testDisabled();
    testReplace();
    testClear();
    testEnableGate();
    testPriority();
    testEventVsClear();
    testUnmapped();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule